// File: doc/BRIEF.md
# In-Order Core Drain Detector

This block decides when an in-order core has truly stopped working and may be reported as halted. It watches the three pipeline registers between fetch, decode, execute and completion. Each register holds two banks of slots, a head bank and a tail bank, and has a stall flag. An unstalled register swaps its banks every cycle. A stalled register does not swap, so work that a producer has just written stays in the tail bank. The block also watches the occupancy of the multi-cycle execute unit, given as two queue counts: operations in flight and operations held back. It also watches a fetch-halted flag and an exception-in-progress flag.

For each pipeline register, the block picks the bank that really holds waiting work. This is the tail bank under stall and the head bank otherwise. It treats the register as busy when any valid bit in that bank is set. The execute unit counts as idle only when both of its queues are empty. The halted output is a register. It rises one edge after every condition holds together, and it then stays set until reset. A long divide that holds the execute unit for dozens of cycles, while every head bank looks empty and fetch has stopped after a mispredict, therefore cannot cause an early halt.

Top module: `core_drain_detect`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, `halted` is 0.
- R2: When a pipeline register's stall flag is 0, its waiting work is its head bank. Any set head valid bit blocks the halt. Tail valid bits of that register have no effect.
- R3: When a pipeline register's stall flag is 1, its waiting work is its tail bank. Any set tail valid bit blocks the halt. Head valid bits of that register have no effect.
- R4: A nonzero count of in-flight execute operations (`exe_pipe_cnt`) blocks the halt for as long as it is nonzero.
- R5: A nonzero count of held-back execute operations (`exe_stallq_cnt`) blocks the halt for as long as it is nonzero.
- R6: While `fetch_halted` is 0, `halted` does not rise.
- R7: While `exc_active` is 1, `halted` does not rise.
- R8: If all conditions hold at a rising clock edge (fetch halted, no register with a valid slot in its selected bank, both execute counts zero, no exception), then `halted` is 1 right after that edge.
- R9: Once `halted` is 1, it stays 1 whatever the inputs do, until reset is asserted.
- R10: The completion register has exactly one slot per bank. Its single valid bit follows the same bank selection as R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fd_head_vld | input | FD_SLOTS | Valid bits of the fetch-to-decode head bank |
| fd_tail_vld | input | FD_SLOTS | Valid bits of the fetch-to-decode tail bank |
| fd_stall | input | 1 | Fetch-to-decode register is stalled |
| dx_head_vld | input | DX_SLOTS | Valid bits of the decode-to-execute head bank |
| dx_tail_vld | input | DX_SLOTS | Valid bits of the decode-to-execute tail bank |
| dx_stall | input | 1 | Decode-to-execute register is stalled |
| cp_head_vld | input | 1 | Valid bit of the completion head slot |
| cp_tail_vld | input | 1 | Valid bit of the completion tail slot |
| cp_stall | input | 1 | Completion register is stalled |
| exe_pipe_cnt | input | CNT_W | Operations in flight in the execute unit |
| exe_stallq_cnt | input | CNT_W | Operations held back in the execute unit |
| fetch_halted | input | 1 | Fetch has stopped |
| exc_active | input | 1 | An exception is being handled |
| halted | output | 1 | Core has drained; sticky until reset |

## Verification
If the block picks the wrong bank for a stalled register or misreads an execute queue, the fault shows on `halted` one edge after the stimulus. The signal rises while work is still pending, and because it is sticky it stays wrong for the rest of the run. The opposite fault, where the block misses that the core is clear, shows as `halted` still being 0 one edge after all conditions hold. The bench therefore samples `halted` exactly one cycle after each change. It also holds blocking states for long stretches, such as a 39-cycle divide, so that a halt which comes too early or too late is caught at once.

// File: rtl/drain_pkg.sv
package drain_pkg;

  localparam int CP_SLOTS = 1;

  typedef struct packed {
    logic fetch_done;
    logic bufs_empty;
    logic exe_idle;
    logic no_exc;
  } drain_cond_t;

  function automatic logic cond_all(input drain_cond_t c);
    return c.fetch_done & c.bufs_empty & c.exe_idle & c.no_exc;
  endfunction

endpackage

// File: rtl/drain_stage_pend.sv
module drain_stage_pend #(
  parameter int SLOTS = 2
) (
  input  logic [SLOTS-1:0] head_vld,
  input  logic [SLOTS-1:0] tail_vld,
  input  logic             stalled,
  output logic             pending
);

  function automatic logic bank_busy(input logic [SLOTS-1:0] v);
    return |v;
  endfunction

  // a stalled register has not swapped: fresh work sits in the tail bank
  function automatic logic [SLOTS-1:0] live_bank(input logic stl,
                                                 input logic [SLOTS-1:0] hd,
                                                 input logic [SLOTS-1:0] tl);
    return stl ? tl : hd;
  endfunction

  logic [SLOTS-1:0] sel_bank;

  always_comb begin
    sel_bank = live_bank(stalled, head_vld, tail_vld);
    pending  = bank_busy(sel_bank);
  end

endmodule

// File: rtl/drain_exec_idle.sv
module drain_exec_idle #(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] pipe_cnt,
  input  logic [CNT_W-1:0] stallq_cnt,
  output logic             idle
);

  function automatic logic queue_empty(input logic [CNT_W-1:0] n);
    return n == '0;
  endfunction

  always_comb idle = queue_empty(pipe_cnt) & queue_empty(stallq_cnt);

endmodule

// File: rtl/drain_halt_latch.sv
module drain_halt_latch
  import drain_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  drain_cond_t cond,
  output logic        halted
);

  logic halted_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halted_q <= 1'b0;
    else        halted_q <= halted_q | cond_all(cond);
  end

  assign halted = halted_q;

endmodule

// File: rtl/core_drain_detect.sv
module core_drain_detect
  import drain_pkg::*;
#(
  parameter  int FD_SLOTS  = 2,
  parameter  int DX_SLOTS  = 2,
  parameter  int EXE_DEPTH = 64,
  localparam int CNT_W     = $clog2(EXE_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FD_SLOTS-1:0] fd_head_vld,
  input  logic [FD_SLOTS-1:0] fd_tail_vld,
  input  logic                fd_stall,
  input  logic [DX_SLOTS-1:0] dx_head_vld,
  input  logic [DX_SLOTS-1:0] dx_tail_vld,
  input  logic                dx_stall,
  input  logic [CP_SLOTS-1:0] cp_head_vld,
  input  logic [CP_SLOTS-1:0] cp_tail_vld,
  input  logic                cp_stall,
  input  logic [CNT_W-1:0]    exe_pipe_cnt,
  input  logic [CNT_W-1:0]    exe_stallq_cnt,
  input  logic                fetch_halted,
  input  logic                exc_active,
  output logic                halted
);

  // named internal events, observed by the bound checker
  logic        fd_pend;
  logic        dx_pend;
  logic        cp_pend;
  logic        exe_idle;
  logic        drain_now;
  drain_cond_t cond;

  drain_stage_pend #(.SLOTS(FD_SLOTS)) u_fd (
    .head_vld (fd_head_vld),
    .tail_vld (fd_tail_vld),
    .stalled  (fd_stall),
    .pending  (fd_pend)
  );

  drain_stage_pend #(.SLOTS(DX_SLOTS)) u_dx (
    .head_vld (dx_head_vld),
    .tail_vld (dx_tail_vld),
    .stalled  (dx_stall),
    .pending  (dx_pend)
  );

  drain_stage_pend #(.SLOTS(CP_SLOTS)) u_cp (
    .head_vld (cp_head_vld),
    .tail_vld (cp_tail_vld),
    .stalled  (cp_stall),
    .pending  (cp_pend)
  );

  drain_exec_idle #(.CNT_W(CNT_W)) u_exe (
    .pipe_cnt   (exe_pipe_cnt),
    .stallq_cnt (exe_stallq_cnt),
    .idle       (exe_idle)
  );

  always_comb begin
    cond.fetch_done = fetch_halted;
    cond.bufs_empty = ~(fd_pend | dx_pend | cp_pend);
    cond.exe_idle   = exe_idle;
    cond.no_exc     = ~exc_active;
    drain_now       = cond_all(cond);
  end

  drain_halt_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond   (cond),
    .halted (halted)
  );

endmodule

// File: rtl/drain_chk.sv
module drain_chk #(
  parameter  int FD_SLOTS  = 2,
  parameter  int EXE_DEPTH = 64,
  localparam int CNT_W     = $clog2(EXE_DEPTH + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [FD_SLOTS-1:0] fd_head_vld,
  input logic [FD_SLOTS-1:0] fd_tail_vld,
  input logic                fd_stall,
  input logic                cp_head_vld,
  input logic                cp_tail_vld,
  input logic                cp_stall,
  input logic                fd_pend,
  input logic                cp_pend,
  input logic [CNT_W-1:0]    exe_pipe_cnt,
  input logic [CNT_W-1:0]    exe_stallq_cnt,
  input logic                exe_idle,
  input logic                fetch_halted,
  input logic                exc_active,
  input logic                drain_now,
  input logic                halted
);

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> !halted); // R1

  AST_HEAD_WHEN_FLOWING: assert property (@(posedge clk) disable iff (!rst_n)
    !fd_stall |-> (fd_pend == (fd_head_vld != '0))); // R2

  AST_TAIL_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    fd_stall |-> (fd_pend == (fd_tail_vld != '0))); // R3

  AST_PIPE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_pipe_cnt != '0) |-> !exe_idle); // R4

  AST_STALLQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_stallq_cnt != '0) |-> !exe_idle); // R5

  AST_FETCH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_halted && !halted) |=> !halted); // R6

  AST_EXC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_active && !halted) |=> !halted); // R7

  AST_DRAIN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    drain_now |=> halted); // R8

  AST_STICKY_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R9

  AST_CP_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cp_pend == (cp_stall ? cp_tail_vld : cp_head_vld)); // R10

endmodule

bind core_drain_detect drain_chk #(
  .FD_SLOTS  (FD_SLOTS),
  .EXE_DEPTH (EXE_DEPTH)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fd_head_vld    (fd_head_vld),
  .fd_tail_vld    (fd_tail_vld),
  .fd_stall       (fd_stall),
  .cp_head_vld    (cp_head_vld[0]),
  .cp_tail_vld    (cp_tail_vld[0]),
  .cp_stall       (cp_stall),
  .fd_pend        (fd_pend),
  .cp_pend        (cp_pend),
  .exe_pipe_cnt   (exe_pipe_cnt),
  .exe_stallq_cnt (exe_stallq_cnt),
  .exe_idle       (exe_idle),
  .fetch_halted   (fetch_halted),
  .exc_active     (exc_active),
  .drain_now      (drain_now),
  .halted         (halted)
);

// File: tb/sim_core_drain_detect.sv
`timescale 1ns/1ps
module sim_core_drain_detect;

  localparam int FD_SLOTS  = 2;
  localparam int DX_SLOTS  = 2;
  localparam int EXE_DEPTH = 64;
  localparam int CNT_W     = $clog2(EXE_DEPTH + 1);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [FD_SLOTS-1:0] fd_head_vld, fd_tail_vld;
  logic                fd_stall;
  logic [DX_SLOTS-1:0] dx_head_vld, dx_tail_vld;
  logic                dx_stall;
  logic [0:0]          cp_head_vld, cp_tail_vld;
  logic                cp_stall;
  logic [CNT_W-1:0]    exe_pipe_cnt, exe_stallq_cnt;
  logic                fetch_halted, exc_active;
  logic                halted;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  core_drain_detect #(.FD_SLOTS(FD_SLOTS), .DX_SLOTS(DX_SLOTS), .EXE_DEPTH(EXE_DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .fd_head_vld(fd_head_vld), .fd_tail_vld(fd_tail_vld), .fd_stall(fd_stall),
    .dx_head_vld(dx_head_vld), .dx_tail_vld(dx_tail_vld), .dx_stall(dx_stall),
    .cp_head_vld(cp_head_vld), .cp_tail_vld(cp_tail_vld), .cp_stall(cp_stall),
    .exe_pipe_cnt(exe_pipe_cnt), .exe_stallq_cnt(exe_stallq_cnt),
    .fetch_halted(fetch_halted), .exc_active(exc_active), .halted(halted)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // every input at the drained value
  task automatic set_clear();
    fd_head_vld = '0; fd_tail_vld = '0; fd_stall = 1'b0;
    dx_head_vld = '0; dx_tail_vld = '0; dx_stall = 1'b0;
    cp_head_vld = '0; cp_tail_vld = '0; cp_stall = 1'b0;
    exe_pipe_cnt = '0; exe_stallq_cnt = '0;
    fetch_halted = 1'b1; exc_active = 1'b0;
  endtask

  // reset with a blocker in place (fetch running)
  task automatic do_reset();
    @(negedge clk);
    set_clear();
    fetch_halted = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic hold_low(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(req, int'(halted), 0);
    end
  endtask

  // caller removes last blocker at a negedge; one edge later halted must be 1
  task automatic expect_rise(input string req);
    @(negedge clk);
    chk(req, int'(halted), 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    set_clear();
    @(negedge clk);
    chk("R1 during reset", int'(halted), 0);
    @(negedge clk);
    chk("R1 during reset, clear inputs", int'(halted), 0);
    fetch_halted = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(halted), 0);
  endtask

  task automatic t_head_flowing();
    do_reset();
    set_clear();
    fd_head_vld = 2'b10;
    hold_low("R2 fd head valid blocks", 4);
    fd_head_vld = '0; dx_head_vld = 2'b01;
    hold_low("R2 dx head valid blocks", 3);
    dx_head_vld = '0; dx_tail_vld = 2'b11; fd_tail_vld = 2'b01;
    expect_rise("R2 tail ignored when flowing");
  endtask

  task automatic t_tail_stalled();
    do_reset();
    set_clear();
    fd_stall = 1'b1; fd_tail_vld = 2'b01;
    hold_low("R3 fd tail valid under stall blocks", 4);
    fd_stall = 1'b0; fd_tail_vld = '0;
    dx_stall = 1'b1; dx_tail_vld = 2'b10; dx_head_vld = '0;
    hold_low("R3 dx tail valid under stall blocks", 3);
    dx_tail_vld = '0; dx_head_vld = 2'b11; fd_stall = 1'b1; fd_head_vld = 2'b11;
    expect_rise("R3 head ignored under stall");
  endtask

  task automatic t_completion();
    do_reset();
    set_clear();
    cp_head_vld = 1'b1;
    hold_low("R10 completion head blocks", 2);
    cp_stall = 1'b1;
    hold_low("R10 completion head ignored needs tail", 0);
    cp_tail_vld = 1'b1;
    hold_low("R10 completion tail under stall blocks", 3);
    cp_tail_vld = 1'b0;
    expect_rise("R10 completion stalled, tail empty");
  endtask

  // long divide: all heads empty, fetch halted, execute unit busy
  task automatic t_divide();
    do_reset();
    set_clear();
    dx_stall = 1'b1; dx_tail_vld = 2'b01;
    exe_pipe_cnt = CNT_W'(1);
    hold_low("R4 divide in flight with stalled tail", 39);
    dx_stall = 1'b0; dx_tail_vld = '0;
    hold_low("R4 divide still in flight", 5);
    exe_pipe_cnt = CNT_W'(EXE_DEPTH);
    hold_low("R4 full execute pipe", 2);
    exe_pipe_cnt = '0;
    expect_rise("R4 divide retired");
  endtask

  task automatic t_stallq();
    do_reset();
    set_clear();
    exe_stallq_cnt = CNT_W'(3);
    hold_low("R5 held-back ops block", 6);
    exe_stallq_cnt = '0;
    expect_rise("R5 held-back queue empty");
  endtask

  task automatic t_fetch_exc();
    do_reset();
    set_clear();
    fetch_halted = 1'b0;
    hold_low("R6 fetch running blocks", 5);
    fetch_halted = 1'b1; exc_active = 1'b1;
    hold_low("R7 exception blocks", 5);
    exc_active = 1'b0;
    expect_rise("R8 rises one edge after all clear");
  endtask

  task automatic t_sticky();
    do_reset();
    set_clear();
    expect_rise("R8 immediate drain");
    fetch_halted = 1'b0; exc_active = 1'b1; fd_head_vld = 2'b11;
    exe_pipe_cnt = CNT_W'(5); exe_stallq_cnt = CNT_W'(2);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R9 halted stays set", int'(halted), 1);
    end
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 cleared by reset", int'(halted), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    set_clear();
    fetch_halted = 1'b0;
    t_reset();
    t_head_flowing();
    t_tail_stalled();
    t_completion();
    t_divide();
    t_stallq();
    t_fetch_exc();
    t_sticky();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule